// File: doc/BRIEF.md
# Bus Address and Strobe Decoder

This block is the combinational glue between a 65816-class processor with a 24-bit address bus and the memories and peripherals on its board. It turns the full address into active-low chip selects for several targets: on-board bank-0 RAM, an EEPROM, a dual UART, a group of VIA-style parallel peripherals and a 4 MB expansion RAM. It also turns the read/write line and the phase-2 clock into one shared active-low read strobe and one shared active-low write strobe. Every device uses these two strobes as its output enable and its write enable.

The chip selects depend only on address bits, so a device is selected as early in the cycle as the address allows. Only the strobes are gated by phase 2. As a result, no device drives the data bus and no write lands while the address is still settling.

The memory map works as follows:
- The lower half of bank 0 is RAM.
- 00:C000 to 00:FFFF is EEPROM.
- 00:8000 to 00:BFFF is an I/O window of eight 2 KB slots.
- Banks 40 to 7F form the expansion RAM window.
- All other banks are left empty.

The VIA-style devices share one I/O slot. Each of them is picked by its own address line, and the low four address bits stay free for register selection.

Top module: `bus_select_decoder`

## Requirements
- R1: The chip-select outputs are independent of `phi2_i`. For a fixed address, every select has the same value with phase 2 low and with phase 2 high.
- R2: `wr_n` is low exactly when `rw_i` is 0 and `phi2_i` is 1. It is high in every other case, including whenever phase 2 is low.
- R3: `rd_n` is low exactly when `rw_i` is 1 and `phi2_i` is 1. It is high in every other case.
- R4: `xram_cs_n` is low for every address from 40:0000 to 7F:FFFF, and high for every other address.
- R5: No chip select is active for addresses 01:0000 to 3F:FFFF or 80:0000 to FF:FFFF.
- R6: `ram_cs_n` is low for addresses 00:0000 to 00:7FFF only.
- R7: `rom_cs_n` is low for addresses 00:C000 to 00:FFFF only.
- R8: The window 00:8000 to 00:BFFF is split into eight 2 KB slots, with the slot number held in A13..A11.
  - Slot 1 (00:8800 to 00:8FFF) asserts `duart_cs_n`.
  - Slots 0 and 3 to 7 assert no chip select.
- R9: In slot 2 (00:9000 to 00:97FF), bit k of `via_cs_n` is low exactly when address line A(4+k) is high, for k from 0 to 6.
  - A0 to A3 never affect any select.
  - Outside slot 2, every bit of `via_cs_n` is high.
- R10: For any address, at most one of these is active: RAM, EEPROM, DUART, expansion RAM, and the VIA group taken as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 24 | Full processor address, bank in bits 23:16 |
| rw_i | input | 1 | Read/write line, 1 = read, 0 = write |
| phi2_i | input | 1 | Phase-2 clock level |
| ram_cs_n | output | 1 | Bank-0 RAM select, active low |
| rom_cs_n | output | 1 | EEPROM select, active low |
| duart_cs_n | output | 1 | DUART select, active low |
| via_cs_n | output | 7 | One select per VIA-style device, active low |
| xram_cs_n | output | 1 | 4 MB expansion RAM select, active low |
| rd_n | output | 1 | Shared read strobe (output enable), active low |
| wr_n | output | 1 | Shared write strobe (write enable), active low |

## Verification
There is no register anywhere in the block. Every select and both strobes settle in the same cycle that the address, R/W or phase-2 input changes, with zero cycles of latency.

The bench applies each new input combination just after a rising edge of its sampling clock. It compares the outputs at the following falling edge, half a period later, when all combinational paths have settled and no edge is in progress.

Each address in the vector table is driven with all four combinations of R/W and phase 2. This shows that the selects do not move with phase 2 and that the strobes follow only R/W and phase 2.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int ADDR_W       = 24;
    localparam int BANK_W       = 8;
    localparam int OFS_W        = ADDR_W - BANK_W;

    // Region decode looks at address bits [23:14] only.
    localparam int REGION_LSB   = 14;
    localparam int REGION_W     = ADDR_W - REGION_LSB;

    // I/O window: eight 2 KB slots selected by A13..A11.
    localparam int SLOT_BITS    = 3;
    localparam int SLOT_LSB     = 11;
    localparam int NUM_SLOTS    = 1 << SLOT_BITS;
    localparam int DUART_SLOT   = 1;
    localparam int VIA_SLOT     = 2;

    // VIA-style devices: one select line each, starting at A4.
    localparam int VIA_COUNT    = 7;
    localparam int VIA_LINE_LSB = 4;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_LORAM,
        RGN_IO,
        RGN_ROM,
        RGN_XRAM
    } region_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    // Classify the upper address bits (A23..A14) into a memory region.
    function automatic region_e classify(input logic [REGION_W-1:0] hi);
        logic [BANK_W-1:0] bank;
        bank = hi[REGION_W-1 -: BANK_W];
        if (bank == '0) begin
            if (!hi[1])     return RGN_LORAM;   // A15 = 0
            else if (hi[0]) return RGN_ROM;     // A15 = 1, A14 = 1
            else            return RGN_IO;      // A15 = 1, A14 = 0
        end else if (bank[BANK_W-1 -: 2] == 2'b01) begin
            return RGN_XRAM;                    // banks 40..7F
        end
        return RGN_NONE;
    endfunction

endpackage

// File: rtl/bsd_region.sv
module bsd_region
    import bsd_pkg::*;
(
    input  logic [REGION_W-1:0] addr_hi,
    output region_e             region
);

    always_comb begin
        region = classify(addr_hi);
    end

    // Banks 01..3F and 80..FF always classify as empty (R5).
    always_comb begin
        if (!$isunknown(addr_hi)) begin
            p_gap_empty_r5: assert (
                !((addr_hi[REGION_W-1 -: BANK_W] != '0) && !addr_hi[REGION_W-1] && !addr_hi[REGION_W-2])
                || region == RGN_NONE);
            p_upper_empty_r5: assert (!addr_hi[REGION_W-1] || region == RGN_NONE);
        end
    end

endmodule

// File: rtl/bsd_io_slots.sv
module bsd_io_slots #(
    parameter int SLOTW = 3
) (
    input  logic                  io_hit,
    input  logic [SLOTW-1:0]      slot_idx,
    output logic [(1<<SLOTW)-1:0] slot_hot
);

    localparam int NSLOT = 1 << SLOTW;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_hot[s] = io_hit && (slot_idx == SLOTW'(s));
    end

    // Exactly one slot fires inside the I/O window and none outside it (R8).
    always_comb begin
        if (!$isunknown({io_hit, slot_idx})) begin
            p_one_slot_r8: assert (io_hit ? ($countones(slot_hot) == 1) : (slot_hot == '0));
        end
    end

endmodule

// File: rtl/bsd_via_lines.sv
module bsd_via_lines #(
    parameter int NVIA = 7
) (
    input  logic            slot_hit,
    input  logic [NVIA-1:0] lines,
    output logic [NVIA-1:0] via_act
);

    for (genvar k = 0; k < NVIA; k++) begin : g_via
        assign via_act[k] = slot_hit & lines[k];
    end

    // No VIA is active unless its slot is hit (R9).
    always_comb begin
        if (!$isunknown({slot_hit, lines})) begin
            p_via_needs_slot_r9: assert (slot_hit || via_act == '0);
        end
    end

endmodule

// File: rtl/bsd_strobes.sv
module bsd_strobes
    import bsd_pkg::*;
(
    input  logic    rw,
    input  logic    phi2,
    output strobe_t stb
);

    always_comb begin
        stb.rd = phi2 &  rw;
        stb.wr = phi2 & ~rw;
    end

    // The two strobes are never active together (R2, R3).
    always_comb begin
        if (!$isunknown({rw, phi2})) begin
            p_strobe_excl_r2: assert (!(stb.rd && stb.wr));
        end
    end

endmodule

// File: rtl/bus_select_decoder.sv
module bus_select_decoder
    import bsd_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rw_i,
    input  logic                 phi2_i,
    output logic                 ram_cs_n,
    output logic                 rom_cs_n,
    output logic                 duart_cs_n,
    output logic [VIA_COUNT-1:0] via_cs_n,
    output logic                 xram_cs_n,
    output logic                 rd_n,
    output logic                 wr_n
);

    region_e                region;
    logic [NUM_SLOTS-1:0]   slot_hot;
    logic [VIA_COUNT-1:0]   via_act;
    strobe_t                stb;
    logic                   reg_sel_unused;

    // A3..A0 are left to the peripherals as register selects.
    assign reg_sel_unused = ^addr_i[VIA_LINE_LSB-1:0];

    bsd_region u_region (
        .addr_hi (addr_i[ADDR_W-1:REGION_LSB]),
        .region  (region)
    );

    bsd_io_slots #(.SLOTW(SLOT_BITS)) u_slots (
        .io_hit   (region == RGN_IO),
        .slot_idx (addr_i[SLOT_LSB +: SLOT_BITS]),
        .slot_hot (slot_hot)
    );

    bsd_via_lines #(.NVIA(VIA_COUNT)) u_via (
        .slot_hit (slot_hot[VIA_SLOT]),
        .lines    (addr_i[VIA_LINE_LSB +: VIA_COUNT]),
        .via_act  (via_act)
    );

    bsd_strobes u_stb (
        .rw   (rw_i),
        .phi2 (phi2_i),
        .stb  (stb)
    );

    // Chip selects are driven from address bits only (R1).
    assign ram_cs_n   = !(region == RGN_LORAM);
    assign rom_cs_n   = !(region == RGN_ROM);
    assign xram_cs_n  = !(region == RGN_XRAM);
    assign duart_cs_n = !slot_hot[DUART_SLOT];
    assign via_cs_n   = ~via_act;
    assign rd_n       = !stb.rd;
    assign wr_n       = !stb.wr;

    always_comb begin
        if (!$isunknown({addr_i, rw_i, phi2_i})) begin
            p_one_target_r10: assert ($onehot0({!ram_cs_n, !rom_cs_n, !duart_cs_n,
                                                !(&via_cs_n), !xram_cs_n}));
            p_no_wr_early_r2: assert (wr_n || phi2_i);
            p_no_rd_early_r3: assert (rd_n || phi2_i);
            p_xram_window_r4: assert (xram_cs_n == (addr_i[ADDR_W-1 -: 2] != 2'b01));
            p_bank0_only_r6:  assert (ram_cs_n || addr_i[ADDR_W-1:OFS_W] == '0);
        end
    end

endmodule

// File: tb/bus_select_decoder_test.sv
module bus_select_decoder_test;

    logic        clk = 1'b0;
    logic [23:0] addr;
    logic        rw;
    logic        phi2;
    logic        ram_cs_n, rom_cs_n, duart_cs_n, xram_cs_n, rd_n, wr_n;
    logic [6:0]  via_cs_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    bus_select_decoder uut (
        .addr_i     (addr),
        .rw_i       (rw),
        .phi2_i     (phi2),
        .ram_cs_n   (ram_cs_n),
        .rom_cs_n   (rom_cs_n),
        .duart_cs_n (duart_cs_n),
        .via_cs_n   (via_cs_n),
        .xram_cs_n  (xram_cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n)
    );

    // Active-high select vector: [0] ram [1] rom [2] duart [9:3] via [10] xram
    function automatic logic [10:0] sel_now();
        return {~xram_cs_n, ~via_cs_n, ~duart_cs_n, ~rom_cs_n, ~ram_cs_n};
    endfunction

    localparam logic [10:0] S_NONE = 11'h000, S_RAM = 11'h001, S_ROM = 11'h002,
                            S_DUA  = 11'h004, S_XRAM = 11'h400;

    // {address, expected selects}
    localparam int NV = 20;
    localparam logic [34:0] VEC [NV] = '{
        {24'h000000, S_RAM},     // R6
        {24'h007FFF, S_RAM},     // R6
        {24'h008000, S_NONE},    // R8 slot 0
        {24'h008800, S_DUA},     // R8 slot 1
        {24'h008FFF, S_DUA},     // R8
        {24'h009010, 11'h008},   // R9 A4 -> via0
        {24'h009400, 11'h200},   // R9 A10 -> via6
        {24'h00900F, S_NONE},    // R9 A0..A3 only
        {24'h0097F0, 11'h3F8},   // R9 all lines
        {24'h009800, S_NONE},    // R8 slot 3
        {24'h00A020, S_NONE},    // R8 slot 4, A5 set
        {24'h00BFFF, S_NONE},    // R8 slot 7
        {24'h00C000, S_ROM},     // R7
        {24'h00FFFF, S_ROM},     // R7
        {24'h010000, S_NONE},    // R5
        {24'h3FFFFF, S_NONE},    // R5
        {24'h400000, S_XRAM},    // R4
        {24'h7FFFFF, S_XRAM},    // R4
        {24'h800000, S_NONE},    // R5
        {24'hFFFFFF, S_NONE}     // R5
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] a, input logic r, input logic p);
        @(posedge clk);
        addr = a; rw = r; phi2 = p;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [10:0] s_lo;
        addr = '0; rw = 1'b1; phi2 = 1'b0;

        // Idle state: address 0, read, phase 2 low
        @(negedge clk);
        check(sel_now() == S_RAM, "R6 idle", 32'(sel_now()), 32'(S_RAM));
        check({rd_n, wr_n} == 2'b11, "R3 idle strobes", 32'({rd_n, wr_n}), 32'h3);

        // Vector walk: every address with both R/W values and both phase-2 levels
        for (int i = 0; i < NV; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic r, p;
                r = c[0]; p = c[1];
                apply(VEC[i][34:11], r, p);
                // R1: expected selects do not depend on phi2
                check(sel_now() == VEC[i][10:0], "R1/R4-R9 selects",
                      32'(sel_now()), 32'(VEC[i][10:0]));
                check(rd_n == !(r && p), "R3 rd_n", 32'(rd_n), 32'(!(r && p)));
                check(wr_n == !(!r && p), "R2 wr_n", 32'(wr_n), 32'(!(!r && p)));
            end
        end

        // R1: phase 2 toggling during a held write leaves the selects unchanged
        apply(24'h008A55, 1'b0, 1'b0);
        s_lo = sel_now();
        check(wr_n == 1'b1, "R2 no write before phi2", 32'(wr_n), 32'h1);
        apply(24'h008A55, 1'b0, 1'b1);
        check(sel_now() == s_lo, "R1 stable over phi2", 32'(sel_now()), 32'(s_lo));
        check(wr_n == 1'b0, "R2 write in phi2", 32'(wr_n), 32'h0);

        // R10: sweep across the map, at most one target group active
        for (int a = 0; a < 24'hFFFFFF; a += 24'h0137F1) begin
            logic [10:0] s;
            apply(24'(a), 1'b1, 1'b1);
            s = sel_now();
            check($countones({s[10], |s[9:3], s[2:0]}) <= 1, "R10 exclusive",
                  32'(s), 32'h0);
            check((a[23:22] == 2'b01) == s[10], "R4 sweep", 32'(s[10]),
                  32'(a[23:22] == 2'b01));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule